// File: doc/BRIEF.md
# Variable-Width Instruction Length Decoder

This block sits at the front of an instruction pipeline for a processor whose operand sizes depend on runtime mode bits. It takes instruction bytes one at a time on a valid/ready stream. From the first byte of each instruction it works out how many operand bytes follow. It gathers those bytes least-significant first into a zero-extended 32-bit operand. It then presents the opcode, the operand, the instruction length and a prefix flag as one record.

The width modes are plain input pins owned by the surrounding processor. The accumulator width code selects 1, 2, 3 or 4 immediate bytes, and the index width code selects 1, 2 or 3. A branch-size pin selects 1- or 3-byte relative offsets. The modes are sampled when the opcode byte is accepted. A dedicated mode-prefix byte (0xF3 by default) forces a 4-byte accumulator immediate for the next instruction only. The prefix byte is absorbed and is never reported as an opcode.

Back-pressure rules: a byte transfers on a rising edge where `in_valid` and `in_ready` are both high. A record transfers where `out_valid` and `out_ready` are both high. While a record is waiting, `in_ready` is low and the record's fields hold steady. The byte stream is therefore stalled until the record is taken. While operand bytes are still arriving, `out_valid` stays low.

Top module: `insn_len_decoder`

## Requirements
- R1: Absolute opcodes always take 3 operand bytes: low nibble 0xC, 0xD, 0xE or 0xF; low nibble 0x9 with bit 4 set; and opcode 0x20.
- R2: Direct-page opcodes take 1 operand byte: low nibble 0x1, 0x3, 0x4, 0x5, 0x6 or 0x7, excluding the prefix code.
- R3: Relative opcodes take 1 operand byte when `rel_long` is 0 and 3 when it is 1: opcode 0x22, opcode 0x80, and low nibble 0x0 with bit 4 set.
- R4: Accumulator immediates (low nibble 0x9, bit 4 clear) take `acc_mode`+1 bytes, where 0=byte, 1=word, 2=24-bit and 3=32-bit.
- R5: Index immediates (0xA0, 0xA2, 0xC0, 0xE0) take 1 byte for `idx_mode`=0, 2 bytes for 1, and 3 bytes for 2 or 3.
- R6: The status set/clear opcodes 0xC2 and 0xE2 always take 3 operand bytes.
- R7: The prefix byte 0xF3 is never output. It makes the next instruction's accumulator immediate 4 bytes and sets `out_prefixed` for that instruction only. Repeated prefixes act as one.
- R8: `out_operand` holds the operand bytes with the first received byte in bits 7:0, and zeros above the last byte.
- R9: `out_len` equals 1 plus the operand byte count. Every other opcode has no operand, giving length 1.
- R10: While `out_valid` is high and `out_ready` is low, the record holds stable and `in_ready` stays low. `out_valid` rises on the edge that accepts the final byte of an instruction and falls on the edge where the record is taken.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and no prefix is pending.
- R12: Changes to the mode pins after the opcode byte is accepted do not alter that instruction's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_mode | input | 2 | Accumulator width code |
| idx_mode | input | 2 | Index width code |
| rel_long | input | 1 | 1 selects 3-byte relative offsets |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input instruction byte |
| in_ready | output | 1 | Decoder can accept a byte |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_operand | output | 32 | Zero-extended little-endian operand |
| out_len | output | 3 | Opcode plus operand bytes (1 to 5) |
| out_prefixed | output | 1 | A prefix preceded this opcode |

## Verification
The bench builds the decoder with its defaults: a 32-bit operand (four operand bytes at most), 3-byte addresses and 0xF3 as the prefix code. These defaults bring every width code into reach, including the full 4-byte immediate and the zero-extension boundary at each length from 1 to 5. Random opcodes, modes, prefixes, input gaps and output stalls are mixed with directed cases. The directed cases cover the 0xF3 0xA9 long-load example, back-to-back prefixes, a prefix in front of a non-accumulator opcode, an operand byte that equals the prefix code, and mode pins changed in the middle of an instruction.

// File: rtl/ild_pkg.sv
package ild_pkg;
  typedef enum logic [2:0] {
    CLS_IMPLIED,
    CLS_DP,
    CLS_ABS,
    CLS_REL,
    CLS_ACC_IMM,
    CLS_IDX_IMM,
    CLS_STAT_IMM,
    CLS_PREFIX
  } op_class_e;
endpackage

// File: rtl/ild_classify.sv
module ild_classify
  import ild_pkg::*;
#(
  parameter logic [7:0] PREFIX_CODE = 8'hF3
) (
  input  logic [7:0] opcode,
  output op_class_e  cls
);
  logic [3:0] lo;
  assign lo = opcode[3:0];

  always_comb begin
    if (opcode == PREFIX_CODE)
      cls = CLS_PREFIX;
    else if (opcode == 8'h22 || opcode == 8'h80 || (lo == 4'h0 && opcode[4]))
      cls = CLS_REL;
    else if (opcode == 8'hC2 || opcode == 8'hE2)
      cls = CLS_STAT_IMM;
    else if (opcode == 8'hA0 || opcode == 8'hA2 || opcode == 8'hC0 || opcode == 8'hE0)
      cls = CLS_IDX_IMM;
    else if (opcode == 8'h20)
      cls = CLS_ABS;
    else if (lo == 4'h9)
      cls = opcode[4] ? CLS_ABS : CLS_ACC_IMM;
    else if (lo >= 4'hC)
      cls = CLS_ABS;
    else if (lo == 4'h1 || lo == 4'h3 || lo == 4'h4 || lo == 4'h5 || lo == 4'h6 || lo == 4'h7)
      cls = CLS_DP;
    else
      cls = CLS_IMPLIED;
  end
endmodule

// File: rtl/ild_len_calc.sv
module ild_len_calc
  import ild_pkg::*;
#(
  parameter int MAX_BYTES  = 4,
  parameter int ADDR_BYTES = 3,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  op_class_e        cls,
  input  logic [1:0]       acc_mode,
  input  logic [1:0]       idx_mode,
  input  logic             rel_long,
  input  logic             force_long,
  output logic [CNT_W-1:0] nbytes
);
  localparam logic [CNT_W-1:0] ADDR_N = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] MAX_N  = CNT_W'(MAX_BYTES);

  logic [CNT_W-1:0] acc_n;
  logic [CNT_W-1:0] idx_n;

  always_comb begin
    acc_n = force_long ? MAX_N : CNT_W'(acc_mode) + CNT_W'(1);
    unique case (idx_mode)
      2'd0:    idx_n = CNT_W'(1);
      2'd1:    idx_n = CNT_W'(2);
      default: idx_n = ADDR_N;
    endcase
  end

  always_comb begin
    unique case (cls)
      CLS_DP:       nbytes = CNT_W'(1);
      CLS_ABS:      nbytes = ADDR_N;
      CLS_STAT_IMM: nbytes = ADDR_N;
      CLS_REL:      nbytes = rel_long ? ADDR_N : CNT_W'(1);
      CLS_ACC_IMM:  nbytes = acc_n;
      CLS_IDX_IMM:  nbytes = idx_n;
      default:      nbytes = '0;
    endcase
  end
endmodule

// File: rtl/ild_collect.sv
module ild_collect #(
  parameter int MAX_BYTES = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int LEN_W    = $clog2(MAX_BYTES + 2),
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int OPND_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              is_prefix,
  input  logic [CNT_W-1:0]  need,
  output logic              pfx_pending,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_opcode,
  output logic [OPND_W-1:0] out_operand,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_prefixed
);
  logic             busy;
  logic [CNT_W-1:0] rem;
  logic [IDX_W-1:0] idx;
  logic             accept;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      rem          <= '0;
      idx          <= '0;
      pfx_pending  <= 1'b0;
      out_valid    <= 1'b0;
      out_opcode   <= '0;
      out_operand  <= '0;
      out_len      <= '0;
      out_prefixed <= 1'b0;
    end else begin
      if (out_valid && out_ready)
        out_valid <= 1'b0;
      if (accept) begin
        if (!busy) begin
          if (is_prefix) begin
            pfx_pending <= 1'b1;
          end else begin
            out_opcode   <= in_data;
            out_operand  <= '0;
            out_len      <= LEN_W'(need) + LEN_W'(1);
            out_prefixed <= pfx_pending;
            pfx_pending  <= 1'b0;
            if (need == '0) begin
              out_valid <= 1'b1;
            end else begin
              busy <= 1'b1;
              rem  <= need;
              idx  <= '0;
            end
          end
        end else begin
          out_operand[8*idx +: 8] <= in_data;
          idx <= idx + IDX_W'(1);
          rem <= rem - CNT_W'(1);
          if (rem == CNT_W'(1)) begin
            busy      <= 1'b0;
            out_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int         OPND_W      = 32,
  parameter int         ADDR_BYTES  = 3,
  parameter logic [7:0] PREFIX_CODE = 8'hF3,
  localparam int        MAX_BYTES   = OPND_W / 8,
  localparam int        CNT_W       = $clog2(MAX_BYTES + 1),
  localparam int        LEN_W       = $clog2(MAX_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_mode,
  input  logic [1:0]        idx_mode,
  input  logic              rel_long,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_opcode,
  output logic [OPND_W-1:0] out_operand,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_prefixed
);
  op_class_e        cls;
  logic [CNT_W-1:0] need;
  logic             pfx_pending;

  ild_classify #(.PREFIX_CODE(PREFIX_CODE)) u_classify (
    .opcode (in_data),
    .cls    (cls)
  );

  ild_len_calc #(.MAX_BYTES(MAX_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_len (
    .cls        (cls),
    .acc_mode   (acc_mode),
    .idx_mode   (idx_mode),
    .rel_long   (rel_long),
    .force_long (pfx_pending),
    .nbytes     (need)
  );

  ild_collect #(.MAX_BYTES(MAX_BYTES)) u_collect (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .is_prefix    (cls == CLS_PREFIX),
    .need         (need),
    .pfx_pending  (pfx_pending),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_opcode   (out_opcode),
    .out_operand  (out_operand),
    .out_len      (out_len),
    .out_prefixed (out_prefixed)
  );
endmodule

// File: rtl/insn_len_decoder_chk.sv
module insn_len_decoder_chk #(
  parameter int         OPND_W      = 32,
  parameter logic [7:0] PREFIX_CODE = 8'hF3,
  localparam int        LEN_W       = $clog2(OPND_W / 8 + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_opcode,
  input logic [OPND_W-1:0] out_operand,
  input logic [LEN_W-1:0]  out_len
);
  localparam int MAXL = OPND_W / 8 + 1;

  logic [OPND_W-1:0] upper;
  assign upper = (int'(out_len) >= 1) ? (out_operand >> (8 * (int'(out_len) - 1))) : out_operand;

  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) &&
                                   $stable(out_operand) && $stable(out_len)));

  assert_len_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_len) >= 1 && int'(out_len) <= MAXL));

  assert_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (upper == '0));

  assert_prefix_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_opcode != PREFIX_CODE));

  assert_abs_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_opcode[3:0] >= 4'hC) |-> (out_len == LEN_W'(4)));

  assert_status_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_opcode == 8'hC2 || out_opcode == 8'hE2)) |-> (out_len == LEN_W'(4)));
endmodule

bind insn_len_decoder insn_len_decoder_chk #(.OPND_W(OPND_W), .PREFIX_CODE(PREFIX_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_opcode  (out_opcode),
  .out_operand (out_operand),
  .out_len     (out_len)
);

// File: tb/insn_len_decoder_tb.sv
module insn_len_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_mode = '0;
  logic [1:0]  idx_mode = '0;
  logic        rel_long = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_opcode;
  logic [31:0] out_operand;
  logic [2:0]  out_len;
  logic        out_prefixed;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_len_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .idx_mode(idx_mode),
    .rel_long(rel_long), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_operand(out_operand), .out_len(out_len),
    .out_prefixed(out_prefixed)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Operand byte count from the requirements; returns the tag of the rule used.
  function automatic int need_bytes(input logic [7:0] op, input logic [1:0] am,
                                    input logic [1:0] xm, input bit rl, input bit pfx,
                                    output string tag);
    logic [3:0] lo = op[3:0];
    if (op == 8'h22 || op == 8'h80 || (lo == 4'h0 && op[4])) begin
      tag = "R3"; return rl ? 3 : 1;
    end
    if (op == 8'hC2 || op == 8'hE2) begin tag = "R6"; return 3; end
    if (op == 8'hA0 || op == 8'hA2 || op == 8'hC0 || op == 8'hE0) begin
      tag = "R5"; return (xm == 2'd0) ? 1 : (xm == 2'd1) ? 2 : 3;
    end
    if (op == 8'h20) begin tag = "R1"; return 3; end
    if (lo == 4'h9 && !op[4]) begin tag = pfx ? "R7" : "R4"; return pfx ? 4 : int'(am) + 1; end
    if (lo == 4'h9 || lo >= 4'hC) begin tag = "R1"; return 3; end
    if (lo == 4'h1 || lo == 4'h3 || (lo >= 4'h4 && lo <= 4'h7)) begin tag = "R2"; return 1; end
    tag = "R9"; return 0;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit gaps);
    if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = $urandom();
  endtask

  task automatic run_insn(input int npfx, input logic [7:0] op, input logic [1:0] am,
                          input logic [1:0] xm, input bit rl, input logic [31:0] val,
                          input bit chg, input bit gaps);
    string tag;
    int n;
    logic [31:0] exp;
    int stall;
    acc_mode = am; idx_mode = xm; rel_long = rl;
    n = need_bytes(op, am, xm, rl, npfx > 0, tag);
    exp = (n >= 4) ? val : (val & ((32'h1 << (8 * n)) - 32'h1));
    for (int p = 0; p < npfx; p++) send_byte(8'hF3, gaps);
    send_byte(op, gaps);
    if (chg) begin
      acc_mode = 2'($urandom()); idx_mode = 2'($urandom()); rel_long = 1'($urandom());
    end
    for (int i = 0; i < n; i++) begin
      if (i == n - 1)
        chk(!out_valid, "R10", "early out_valid", 32'(out_valid), 32'd0);
      send_byte(val[8*i +: 8], gaps);
    end
    chk(out_valid, "R10", "out_valid after last byte", 32'(out_valid), 32'd1);
    chk(out_opcode == op, tag, "opcode", 32'(out_opcode), 32'(op));
    chk(int'(out_len) == n + 1, chg ? "R12" : tag, "length", 32'(out_len), 32'(n + 1));
    chk(out_operand == exp, "R8", "operand", out_operand, exp);
    chk(out_prefixed == (npfx > 0), "R7", "prefixed flag", 32'(out_prefixed), 32'(npfx > 0));
    stall = $urandom_range(0, 3);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && !in_ready && out_operand == exp && out_opcode == op,
          "R10", "hold under stall", out_operand, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R10", "record taken", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!out_valid, "R11", "out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready, "R11", "in_ready after reset", 32'(in_ready), 32'd1);
    // R11: no pending prefix, byte-mode immediate is 2 long
    run_insn(0, 8'hA9, 2'd0, 2'd0, 1'b0, 32'h12, 1'b0, 1'b0);
    // R7: long-load example F3 A9 EF BE AD DE
    run_insn(1, 8'hA9, 2'd0, 2'd0, 1'b0, 32'hDEADBEEF, 1'b0, 1'b0);
    // R7: prefix is one-shot
    run_insn(0, 8'hA9, 2'd0, 2'd0, 1'b0, 32'h77, 1'b0, 1'b0);
    // R7: repeated prefixes act as one
    run_insn(2, 8'h69, 2'd1, 2'd0, 1'b0, 32'hCAFEF00D, 1'b0, 1'b0);
    // R7/R5: prefix before index immediate does not change its length
    run_insn(1, 8'hA0, 2'd0, 2'd0, 1'b0, 32'h5A, 1'b0, 1'b0);
    // R8: operand byte equal to prefix code is data
    run_insn(0, 8'hAD, 2'd0, 2'd0, 1'b0, 32'h00F3F3F3, 1'b0, 1'b0);
    // R3 both sizes, call opcode 0x22
    run_insn(0, 8'h22, 2'd0, 2'd0, 1'b0, 32'h00000081, 1'b0, 1'b0);
    run_insn(0, 8'h22, 2'd0, 2'd0, 1'b1, 32'h00FFFFFE, 1'b0, 1'b0);
    // R6 status ops, R9 implied
    run_insn(0, 8'hC2, 2'd3, 2'd0, 1'b1, 32'h00123456, 1'b0, 1'b0);
    run_insn(0, 8'hEA, 2'd3, 2'd2, 1'b1, 32'h0, 1'b0, 1'b0);
    // R12: modes change mid-instruction
    run_insn(0, 8'hA9, 2'd3, 2'd0, 1'b0, 32'h89ABCDEF, 1'b1, 1'b0);
    run_insn(0, 8'hE0, 2'd0, 2'd1, 1'b0, 32'h0000BEEF, 1'b1, 1'b0);
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 3);
      if (sel == 0) op = {3'($urandom()), 5'h09};
      else op = 8'($urandom());
      if (op == 8'hF3) op = 8'hA9;
      run_insn(($urandom_range(0, 3) == 0) ? 1 : 0, op, 2'($urandom()), 2'($urandom()),
               1'($urandom()), $urandom(), ($urandom_range(0, 7) == 0), 1'b1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule